// File: doc/BRIEF.md
# Selectable Truncate or Round Right-Shifter

This block lowers the precision of a signed two's complement word by an arithmetic right shift of a run-time amount T, which scales the word by 2^-T. A mode input picks one of two quantizers that share one datapath. Truncation keeps the largest output level that does not exceed the input, so its error always points toward negative infinity. Rounding adds half an output step before the shift, which gives the nearest level and sends exact halves upward.

Next to the reduced word the block reports what the shift threw away. One flag says the discarded bits were all zero, so the result is exact. The other says they were all ones, which is the worst case for truncation: an error of 1 - 2^-T of one output step. Each input marked valid produces its result, flags and a valid strobe one clock later. A rounding result that would pass the largest positive value is clipped to it.

Top module: `qshift_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low, `out_data` and both flags keep their previous values.
- R2: While `rst` is high at a clock edge, `out_valid`, `out_data`, `out_lost_zero` and `out_lost_ones` are cleared to 0.
- R3: With `in_round` = 0 (truncate), `out_data` = floor(`in_data` / 2^T). Examples: 31 with T=4 gives 1, 63 with T=4 gives 3, -3 with T=1 gives -2, and -24 with T=4 gives -2.
- R4: With `in_round` = 1 (round), `out_data` = floor((`in_data` + 2^(T-1)) / 2^T), so halves go upward. Examples with T=1: 1 gives 1, -1 gives 0, 3 gives 2, -3 gives -1. Example with T=4: -24 gives -1.
- R5: With T = 0 the word passes through unchanged in both modes, `out_lost_zero` = 1 and `out_lost_ones` = 0.
- R6: `out_lost_zero` = 1 exactly when the T low bits of the input are all zero. In truncate mode this is exactly the case where `out_data` * 2^T equals the input.
- R7: `out_lost_ones` = 1 exactly when T >= 1 and the T low bits of the input are all ones. In truncate mode the error is then 2^T - 1 input units. The two flags are never high together.
- R8: The residual, input minus `out_data` * 2^T, lies in [0, 2^T) for truncation and in [-2^(T-1), 2^(T-1)) for rounding with T >= 1.
- R9: A rounding result never wraps. Values above the largest positive output clip to it, and a non-negative input never gives a negative output. Example: 0x7FFF with T=15 gives 1.
- R10: `in_shift` is log2(DATA_W) bits wide and can reach DATA_W-1. Example: 0x8000 with T=15 gives -1 (0xFFFF) in both modes, with the zero flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid this cycle |
| in_data | input | DATA_W | Signed two's complement word to reduce |
| in_shift | input | SHIFT_W | Shift amount T, 0 to DATA_W-1 |
| in_round | input | 1 | 0 = truncate, 1 = round half up |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | DATA_W | Reduced signed word |
| out_lost_zero | output | 1 | Discarded bits were all zero |
| out_lost_ones | output | 1 | T >= 1 and discarded bits were all ones |

## Verification
The result word, both flags and the valid strobe all come from one register stage. Each one is therefore due at the first rising edge after the cycle in which `in_valid` was seen high. The bench drives every stimulus on a falling edge and samples all four outputs at the next falling edge, half a period after that rising edge. For the hold behaviour it holds `in_valid` low while it changes the data inputs, then checks one falling edge later that the outputs stayed the same and `out_valid` dropped.

// File: rtl/qshift_pkg.sv
package qshift_pkg;

    // Quantizer selection, taken straight from the in_round pin.
    typedef enum logic {
        QS_TRUNC = 1'b0,
        QS_ROUND = 1'b1
    } qs_mode_e;

    // Width of a shift count able to address every bit of a word.
    function automatic int count_width(input int unsigned word_w);
        return (word_w > 1) ? $clog2(word_w) : 1;
    endfunction

endpackage

// File: rtl/qshift_mask.sv
// Marks the bit positions an arithmetic right shift by 'shift' drops.
module qshift_mask #(
    parameter int WORD_W  = 16,
    parameter int COUNT_W = 4
) (
    input  logic [COUNT_W-1:0] shift,
    output logic [WORD_W-1:0]  drop_mask
);
    for (genvar gi = 0; gi < WORD_W; gi++) begin : g_bit
        assign drop_mask[gi] = (32'(shift) > gi);
    end
endmodule

// File: rtl/qshift_flags.sv
// Classifies the discarded bits as all zero or all ones.
module qshift_flags #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] drop_mask,
    output logic              all_zero,
    output logic              all_ones
);
    logic [WORD_W-1:0] dropped;

    always_comb begin
        dropped  = word & drop_mask;
        all_zero = ~|dropped;
        // An empty field counts as exact, never as the worst case.
        all_ones = (|drop_mask) && (dropped == drop_mask);
    end
endmodule

// File: rtl/qshift_core.sv
// Shared bias-add and arithmetic shift for both quantizers, with clip guard.
module qshift_core
    import qshift_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int COUNT_W = 4
) (
    input  logic [WORD_W-1:0]  word,
    input  logic [COUNT_W-1:0] shift,
    input  qs_mode_e           mode,
    output logic [WORD_W-1:0]  result
);
    localparam int EXT_W = WORD_W + 1;
    localparam logic [WORD_W-1:0] MAX_POS = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] MAX_NEG = {1'b1, {(WORD_W-1){1'b0}}};

    logic signed [EXT_W-1:0] bias;
    logic signed [EXT_W-1:0] sum;
    logic signed [EXT_W-1:0] shifted;
    logic                    over_pos;
    logic                    over_neg;

    always_comb begin
        bias = '0;
        if (mode == QS_ROUND && shift != '0) begin
            bias = EXT_W'(1) << (shift - COUNT_W'(1));
        end
        sum      = $signed({word[WORD_W-1], word}) + bias;
        shifted  = sum >>> shift;
        over_pos = !shifted[EXT_W-1] &&  shifted[EXT_W-2];
        over_neg =  shifted[EXT_W-1] && !shifted[EXT_W-2];
        if (over_pos) begin
            result = MAX_POS;
        end else if (over_neg) begin
            result = MAX_NEG;
        end else begin
            result = shifted[WORD_W-1:0];
        end
    end
endmodule

// File: rtl/qshift_unit.sv
module qshift_unit
    import qshift_pkg::*;
#(
    parameter  int DATA_W  = 16,
    localparam int SHIFT_W = count_width(DATA_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [SHIFT_W-1:0] in_shift,
    input  logic               in_round,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_lost_zero,
    output logic               out_lost_ones
);
    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              lost_zero;
        logic              lost_ones;
    } qs_result_t;

    qs_mode_e          mode;
    logic [DATA_W-1:0] drop_mask;
    qs_result_t        res_d;
    qs_result_t        res_q;
    logic              valid_q;

    assign mode = qs_mode_e'(in_round);

    qshift_mask #(.WORD_W(DATA_W), .COUNT_W(SHIFT_W)) u_mask (
        .shift     (in_shift),
        .drop_mask (drop_mask)
    );

    qshift_flags #(.WORD_W(DATA_W)) u_flags (
        .word      (in_data),
        .drop_mask (drop_mask),
        .all_zero  (res_d.lost_zero),
        .all_ones  (res_d.lost_ones)
    );

    qshift_core #(.WORD_W(DATA_W), .COUNT_W(SHIFT_W)) u_core (
        .word   (in_data),
        .shift  (in_shift),
        .mode   (mode),
        .result (res_d.value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign out_valid     = valid_q;
    assign out_data      = res_q.value;
    assign out_lost_zero = res_q.lost_zero;
    assign out_lost_ones = res_q.lost_ones;

    // Checking state: the accepted operands, kept to rebuild the residual.
    localparam int RES_W = 2 * DATA_W + 1;

    logic [DATA_W-1:0]  chk_in;
    logic [SHIFT_W-1:0] chk_shift;
    qs_mode_e           chk_mode;
    logic signed [RES_W-1:0] chk_in_ext;
    logic signed [RES_W-1:0] chk_out_ext;
    logic signed [RES_W-1:0] chk_step;
    logic signed [RES_W-1:0] chk_half;
    logic signed [RES_W-1:0] chk_resid;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_in    <= '0;
            chk_shift <= '0;
            chk_mode  <= QS_TRUNC;
        end else if (in_valid) begin
            chk_in    <= in_data;
            chk_shift <= in_shift;
            chk_mode  <= mode;
        end
    end

    always_comb begin
        chk_in_ext  = RES_W'($signed(chk_in));
        chk_out_ext = RES_W'($signed(out_data));
        chk_step    = RES_W'(1) << chk_shift;
        chk_half    = chk_step >>> 1;
        chk_resid   = chk_in_ext - (chk_out_ext <<< chk_shift);
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);  // R1
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);  // R1
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data) && $stable(out_lost_zero) && $stable(out_lost_ones));  // R1
    AST_PASS_T0: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_shift == '0 |=> out_data == $past(in_data) && out_lost_zero);  // R5
    AST_EXACT_WHEN_CLEAN: assert property (@(posedge clk) disable iff (rst)
        out_valid && chk_mode == QS_TRUNC |-> out_lost_zero == (chk_resid == '0));  // R6
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_lost_zero && out_lost_ones));  // R7
    AST_WORST_TRUNC: assert property (@(posedge clk) disable iff (rst)
        out_valid && chk_mode == QS_TRUNC && out_lost_ones |-> chk_resid == chk_step - 1);  // R7
    AST_TRUNC_RESID: assert property (@(posedge clk) disable iff (rst)
        out_valid && chk_mode == QS_TRUNC |-> chk_resid >= 0 && chk_resid < chk_step);  // R8
    AST_ROUND_RESID: assert property (@(posedge clk) disable iff (rst)
        out_valid && chk_mode == QS_ROUND && chk_shift != '0
        |-> chk_resid >= -chk_half && chk_resid < chk_half);  // R8
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        out_valid && chk_mode == QS_ROUND && !chk_in[DATA_W-1] |-> !out_data[DATA_W-1]);  // R9

endmodule

// File: tb/qshift_unit_tb.sv
module qshift_unit_tb;
    localparam int DW = 16;
    localparam int SW = 4;

    typedef struct packed {
        logic          rnd;
        logic [SW-1:0] sh;
        logic [DW-1:0] din;
        logic [DW-1:0] exp;
        logic          ez;
        logic          eo;
    } vec_t;

    localparam int NV = 12;
    // Encoding: rnd 0 = truncate, 1 = round; sh is T; flags are zero, ones.
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd4, 16'd31,    16'd1,    1'b0, 1'b1},  // R3
        '{1'b0, 4'd4, 16'd63,    16'd3,    1'b0, 1'b1},  // R3
        '{1'b0, 4'd1, 16'hFFFD,  16'hFFFE, 1'b0, 1'b1},  // R3 -1.5 -> -2
        '{1'b0, 4'd4, 16'd48,    16'd3,    1'b1, 1'b0},  // R3
        '{1'b0, 4'd4, 16'hFFE8,  16'hFFFE, 1'b0, 1'b0},  // R3
        '{1'b1, 4'd1, 16'd1,     16'd1,    1'b0, 1'b1},  // R4
        '{1'b1, 4'd1, 16'hFFFF,  16'd0,    1'b0, 1'b1},  // R4
        '{1'b1, 4'd1, 16'd3,     16'd2,    1'b0, 1'b1},  // R4
        '{1'b1, 4'd1, 16'hFFFD,  16'hFFFF, 1'b0, 1'b1},  // R4
        '{1'b1, 4'd4, 16'd24,    16'd2,    1'b0, 1'b0},  // R4
        '{1'b1, 4'd4, 16'd23,    16'd1,    1'b0, 1'b0},  // R4
        '{1'b1, 4'd4, 16'hFFE8,  16'hFFFF, 1'b0, 1'b0}   // R4
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [SW-1:0] in_shift = '0;
    logic          in_round = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_lost_zero;
    logic          out_lost_ones;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    qshift_unit #(.DATA_W(DW)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_shift      (in_shift),
        .in_round      (in_round),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .out_lost_zero (out_lost_zero),
        .out_lost_ones (out_lost_ones)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run(input bit rnd, input int sh, input logic [DW-1:0] d,
                       input logic [DW-1:0] e, input bit ez, input bit eo,
                       input string tag, input string ftag);
        @(negedge clk);
        in_valid = 1'b1;
        in_round = rnd;
        in_shift = SW'(sh);
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", "out_valid", int'(out_valid), 1);
        check(tag, "out_data", int'(out_data), int'(e));
        check(ftag, "lost_zero", int'(out_lost_zero), int'(ez));
        check(ftag, "lost_ones", int'(out_lost_ones), int'(eo));
    endtask

    function automatic int floor_div(input int x, input int d);
        int q;
        q = x / d;
        if (x < 0 && q * d != x) q = q - 1;
        return q;
    endfunction

    initial begin
        // R2: reset state
        repeat (3) @(negedge clk);
        check("R2", "out_valid", int'(out_valid), 0);
        check("R2", "out_data", int'(out_data), 0);
        check("R2", "lost_zero", int'(out_lost_zero), 0);
        check("R2", "lost_ones", int'(out_lost_ones), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "idle out_valid", int'(out_valid), 0);

        // Table of vectors: R3 truncation, R4 rounding, flags R6 R7
        for (int i = 0; i < NV; i++) begin
            run(VECS[i].rnd, int'(VECS[i].sh), VECS[i].din, VECS[i].exp,
                VECS[i].ez, VECS[i].eo, VECS[i].rnd ? "R4" : "R3", "R6 R7");
        end

        // R5: zero shift passes through
        run(1'b0, 0, 16'h1234, 16'h1234, 1'b1, 1'b0, "R5", "R5");
        run(1'b1, 0, 16'h8000, 16'h8000, 1'b1, 1'b0, "R5", "R5");

        // R9: rounding near the positive limit never wraps
        run(1'b1, 1, 16'h7FFF, 16'h4000, 1'b0, 1'b1, "R9", "R7");
        run(1'b1, 15, 16'h7FFF, 16'd1, 1'b0, 1'b1, "R9", "R7");

        // R10: largest shift amount
        run(1'b0, 15, 16'h8000, 16'hFFFF, 1'b1, 1'b0, "R10", "R6");
        run(1'b1, 15, 16'h8000, 16'hFFFF, 1'b1, 1'b0, "R10", "R6");

        // R1: inputs changing with in_valid low leave the outputs alone
        @(negedge clk);
        in_data  = 16'h5555;
        in_shift = 4'd3;
        in_round = 1'b0;
        @(negedge clk);
        check("R1", "hold out_valid", int'(out_valid), 0);
        check("R1", "hold out_data", int'(out_data), 16'hFFFF);
        check("R1", "hold lost_zero", int'(out_lost_zero), 1);
        check("R1", "hold lost_ones", int'(out_lost_ones), 0);

        // R8: sweep against a floor-division model
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int k = 0; k < 400; k++) begin
                int x, t, d, e, low;
                bit rnd;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                x   = int'($signed(lfsr));
                t   = (k * 7 + int'(lfsr[3:0])) % DW;
                rnd = k[0];
                d   = 1 << t;
                e   = floor_div(rnd && t > 0 ? x + d / 2 : x, d);
                if (e > 32767) e = 32767;
                low = x & (d - 1);
                run(rnd, t, lfsr, DW'(e), low == 0, t > 0 && low == d - 1, "R8", "R6 R7");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule